// File: doc/BRIEF.md
# Pulse-Swallow Programmable Counter Pair

This block is the programmable back end of a dual-band integer-N frequency divider. It runs on the output clock of a multimodulus prescaler. It holds a 7-bit loadable down counter (P) and a 6-bit loadable swallow counter (S). From these it drives the prescaler modulus control and emits one divided-output pulse per full division cycle. The band select does two jobs. It picks the prescaler modulus pair, which is 32/33 in the low band and 47/48 in the high band. It is also wired into the second-highest bit of the P count. The top bit of the P count is always 1.

A division cycle lasts P prescaler-output periods. During the first S of those periods the modulus control is low. For the remaining P−S periods it is high. The S counter stops at zero and stays there until the next reload. When P runs out, a one-cycle load strobe reloads both counters and clears the modulus control. The strobe also serves as the divided output.

The prescaler maps the control differently in each band:
- Low band: control high selects 32 and control low selects 33, so the ratio is 32·P+S.
- High band: control high selects 48 and control low selects 47, so the ratio is 48·P−S.

Top module: `pswallow_counter_pair`

## Requirements
- R1: While reset is held (synchronous, active low), mod_ctl is 1, load_stb and div_out are 1 and prog_err is 0, so the first clock edge after reset performs a load.
- R2: The effective P value is {1, band_sel, p_prog[4:0]} (a value of 64 to 127), and consecutive load strobes are exactly P clock cycles apart, with the strobe cycle counted as the last cycle of its division cycle.
- R3: After a load, mod_ctl is 0 for exactly the first S cycles of the division cycle and 1 for the remaining P−S cycles, the strobe cycle included.
- R4: Once mod_ctl is 1, the swallow counter is frozen at zero and mod_ctl stays 1 until the next load.
- R5: load_stb is high for exactly one cycle per division cycle, and div_out equals load_stb on every cycle.
- R6: With band_sel=0 and a prescaler giving 32 when mod_ctl=1 and 33 when mod_ctl=0, one division cycle spans 32·P+S prescaler input cycles (for example, P=77 and S=6 give 2470).
- R7: With band_sel=1 and a prescaler giving 48 when mod_ctl=1 and 47 when mod_ctl=0, one division cycle spans 48·P−S input cycles (for example, P=122 and S=38 give 5818).
- R8: In the low band, bit 5 of s_prog is ignored, so the swallow counter loads s_prog[4:0].
- R9: At each load, prog_err is set if band_sel=0 and s_prog exceeds 31, or if the loaded S is not less than P, and is cleared otherwise. It holds its value until the next load.
- R10: band_sel, p_prog and s_prog are sampled only on the load edge. A change in the middle of a division cycle first shows in the next division cycle.
- R11: Stepping s_prog by K changes the division ratio by +K in the low band and by −K in the high band.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Synchronous active-low reset |
| band_sel | input | 1 | 0 = low band (32/33), 1 = high band (47/48); also bit 5 of P |
| p_prog | input | 5 | Low five bits of the P program word |
| s_prog | input | 6 | Swallow count program word |
| mod_ctl | output | 1 | Prescaler modulus control |
| div_out | output | 1 | Divided output pulse, one clock wide |
| load_stb | output | 1 | Reload strobe at end of P count |
| prog_err | output | 1 | Program word fault latched at the last load |

## Verification
The in-line assertions check four properties on every cycle:
- the strobe never lasts more than one cycle;
- the modulus control never falls between loads;
- the swallow count is frozen once the control is high, and is nonzero while it is low;
- the error flag changes only at a load.

Only the directed scenarios can show the cycle counts that matter, using a behavioural prescaler model. They measure the P-cycle spacing, the exact count of swallow cycles, and the resulting 32·P+S and 48·P−S ratios. They also cover the masked S top bit in the low band and the deferral of program changes made in the middle of a cycle.

// File: rtl/pdiv_pkg.sv
// Shared definitions for the pulse-swallow counter pair.
// Assumes: P is at least two bits wider than the band-independent P field.
package pdiv_pkg;
    typedef enum logic {
        BAND_LO = 1'b0,
        BAND_HI = 1'b1
    } band_t;

    localparam int DEF_P_WIDTH    = 7;
    localparam int DEF_S_WIDTH    = 6;
    localparam int DEF_LO_S_WIDTH = 5;
endpackage

// File: rtl/pdiv_p_counter.sv
// Programmable P down counter. Effective count is {1, band, p_lo}.
// Raises load_o for one cycle when the count reaches zero and reloads P-1
// on that edge, so strobes are P cycles apart.
// Assumes: P_WIDTH >= 3; reset leaves the count at zero so the first edge loads.
module pdiv_p_counter #(
    parameter int P_WIDTH = pdiv_pkg::DEF_P_WIDTH,
    localparam int PL_WIDTH = P_WIDTH - 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  pdiv_pkg::band_t     band_i,
    input  logic [PL_WIDTH-1:0] p_lo_i,
    output logic                load_o
);
    logic [P_WIDTH-1:0] p_cnt;
    logic [P_WIDTH-1:0] p_eff;

    // Assemble the effective P word with the fixed top bit and the band bit.
    assign p_eff  = {1'b1, band_i, p_lo_i};
    assign load_o = (p_cnt == '0);

    // Count down; on the strobe cycle reload P-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_cnt <= '0;
        end else if (load_o) begin
            p_cnt <= p_eff - P_WIDTH'(1);
        end else begin
            p_cnt <= p_cnt - P_WIDTH'(1);
        end
    end

    // Strobe is a single cycle wide because P-1 is never zero.
    p_single_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !load_o);
endmodule

// File: rtl/pdiv_s_counter.sv
// Swallow counter. Loads S at the strobe and counts down while the modulus
// control is low. Sets the control when the count reaches zero, then holds
// its state frozen until the next strobe. In the low band the bits at and
// above LO_S_WIDTH are forced to zero.
// Assumes: LO_S_WIDTH < S_WIDTH.
module pdiv_s_counter #(
    parameter int S_WIDTH    = pdiv_pkg::DEF_S_WIDTH,
    parameter int LO_S_WIDTH = pdiv_pkg::DEF_LO_S_WIDTH
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  pdiv_pkg::band_t    band_i,
    input  logic [S_WIDTH-1:0] s_i,
    output logic               mod_o
);
    logic [S_WIDTH-1:0] s_eff;
    logic [S_WIDTH-1:0] s_cnt;
    logic               mod_q;

    // Per-bit band masking of the program word.
    for (genvar i = 0; i < S_WIDTH; i++) begin : g_mask
        if (i < LO_S_WIDTH) begin : g_keep
            assign s_eff[i] = s_i[i];
        end else begin : g_band
            assign s_eff[i] = s_i[i] & (band_i == pdiv_pkg::BAND_HI);
        end
    end

    assign mod_o = mod_q;

    // Load on strobe, count down while active, freeze once zero is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_cnt <= '0;
            mod_q <= 1'b1;
        end else if (load_i) begin
            s_cnt <= s_eff;
            mod_q <= (s_eff == '0);
        end else if (!mod_q) begin
            s_cnt <= s_cnt - S_WIDTH'(1);
            if (s_cnt == S_WIDTH'(1)) begin
                mod_q <= 1'b1;
            end
        end
    end

    // Frozen state while the modulus control is high.
    p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_q && !load_i) |=> $stable(s_cnt));
    // Control low only while swallow cycles remain.
    p_active_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mod_q && !load_i) |-> (s_cnt != '0));
endmodule

// File: rtl/pdiv_prog_check.sv
// Program word checker. At each strobe it flags an S value that is not below
// P, or a low-band S with bits set at or above LO_S_WIDTH. The flag holds
// for the whole division cycle.
// Assumes: P_WIDTH >= S_WIDTH.
module pdiv_prog_check #(
    parameter int P_WIDTH    = pdiv_pkg::DEF_P_WIDTH,
    parameter int S_WIDTH    = pdiv_pkg::DEF_S_WIDTH,
    parameter int LO_S_WIDTH = pdiv_pkg::DEF_LO_S_WIDTH,
    localparam int PL_WIDTH  = P_WIDTH - 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  pdiv_pkg::band_t     band_i,
    input  logic [PL_WIDTH-1:0] p_lo_i,
    input  logic [S_WIDTH-1:0]  s_i,
    output logic                err_o
);
    logic [P_WIDTH-1:0] p_eff;
    logic [S_WIDTH-1:0] s_eff;
    logic               hi_bits;
    logic               too_big;

    // Derive the values the counters will load.
    always_comb begin
        p_eff   = {1'b1, band_i, p_lo_i};
        hi_bits = (s_i[S_WIDTH-1:LO_S_WIDTH] != '0);
        s_eff   = s_i;
        if (band_i == pdiv_pkg::BAND_LO) begin
            s_eff[S_WIDTH-1:LO_S_WIDTH] = '0;
        end
        too_big = (P_WIDTH'(s_eff) >= p_eff);
    end

    // Capture the fault on the strobe edge only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_o <= 1'b0;
        end else if (load_i) begin
            err_o <= too_big || (hi_bits && (band_i == pdiv_pkg::BAND_LO));
        end
    end

    p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(err_o));
endmodule

// File: rtl/pswallow_counter_pair.sv
// Top of the pulse-swallow counter pair. The P counter paces the division
// cycle. The S counter sets the modulus control after S swallow cycles.
// The checker validates the program words. The strobe doubles as the
// divided output.
// Assumes: clk is the prescaler output; program words are static around
// the strobe edge.
module pswallow_counter_pair #(
    parameter int P_WIDTH    = pdiv_pkg::DEF_P_WIDTH,
    parameter int S_WIDTH    = pdiv_pkg::DEF_S_WIDTH,
    parameter int LO_S_WIDTH = pdiv_pkg::DEF_LO_S_WIDTH
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 band_sel,
    input  logic [P_WIDTH-3:0]   p_prog,
    input  logic [S_WIDTH-1:0]   s_prog,
    output logic                 mod_ctl,
    output logic                 div_out,
    output logic                 load_stb,
    output logic                 prog_err
);
    pdiv_pkg::band_t band;

    // Map the raw select pin onto the band type.
    assign band    = pdiv_pkg::band_t'(band_sel);
    assign div_out = load_stb;

    pdiv_p_counter #(.P_WIDTH(P_WIDTH)) u_pcnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .band_i (band),
        .p_lo_i (p_prog),
        .load_o (load_stb)
    );

    pdiv_s_counter #(.S_WIDTH(S_WIDTH), .LO_S_WIDTH(LO_S_WIDTH)) u_scnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_stb),
        .band_i (band),
        .s_i    (s_prog),
        .mod_o  (mod_ctl)
    );

    pdiv_prog_check #(.P_WIDTH(P_WIDTH), .S_WIDTH(S_WIDTH), .LO_S_WIDTH(LO_S_WIDTH)) u_chk (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_stb),
        .band_i (band),
        .p_lo_i (p_prog),
        .s_i    (s_prog),
        .err_o  (prog_err)
    );

    // Modulus control never falls inside a division cycle.
    p_mod_monotonic_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_stb && mod_ctl) |=> mod_ctl);
    // With valid words the swallow phase ends before the P count does.
    p_mod_at_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && !prog_err) |-> mod_ctl);
endmodule

// File: tb/pswallow_counter_pair_bench.sv
module pswallow_counter_pair_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       band_sel = 1'b0;
    logic [4:0] p_prog = 5'd13;
    logic [5:0] s_prog = 6'd6;
    logic       mod_ctl, div_out, load_stb, prog_err;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    pswallow_counter_pair u_pswallow_counter_pair (
        .clk      (clk),
        .rst_n    (rst_n),
        .band_sel (band_sel),
        .p_prog   (p_prog),
        .s_prog   (s_prog),
        .mod_ctl  (mod_ctl),
        .div_out  (div_out),
        .load_stb (load_stb),
        .prog_err (prog_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Behavioural prescaler: input cycles per output cycle.
    function automatic int modulus(input logic band, input logic m);
        if (band) return m ? 48 : 47;
        return m ? 32 : 33;
    endfunction

    task automatic wait_load();
        while (!load_stb) @(negedge clk);
    endtask

    // Called at a negedge where load_stb is high; walks one division cycle.
    // Optionally changes the program words after chg_at samples.
    task automatic measure(input logic band, input int chg_at,
                           input logic nb, input logic [4:0] np, input logic [5:0] ns,
                           output int cyc, output int zeros, output int ratio,
                           output int mono_bad, output int div_bad, output int err_first);
        bit seen_one = 0;
        cyc = 0; zeros = 0; ratio = 0; mono_bad = 0; div_bad = 0; err_first = 0;
        do begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) err_first = int'(prog_err);
            if (!mod_ctl) begin
                zeros++;
                if (seen_one) mono_bad++;
            end else begin
                seen_one = 1;
            end
            if (div_out !== load_stb) div_bad++;
            if (load_stb && cyc == 1) div_bad++;
            ratio += modulus(band, mod_ctl);
            if (cyc == chg_at) begin
                band_sel = nb; p_prog = np; s_prog = ns;
            end
        end while (!load_stb && cyc < 400);
    endtask

    task automatic run_case(input string req, input logic band, input logic [4:0] p,
                            input logic [5:0] s, input int exp_p, input int exp_s,
                            input int exp_ratio, input int exp_err);
        int cyc, zeros, ratio, mono_bad, div_bad, err_first;
        band_sel = band; p_prog = p; s_prog = s;
        wait_load();
        measure(band, 0, band, p, s, cyc, zeros, ratio, mono_bad, div_bad, err_first);
        chk(cyc == exp_p, {req, " R2 period"}, cyc, exp_p);
        chk(zeros == exp_s, {req, " R3 swallow cycles"}, zeros, exp_s);
        chk(mono_bad == 0, {req, " R4 control stays high"}, mono_bad, 0);
        chk(div_bad == 0, {req, " R5 div_out pulse"}, div_bad, 0);
        chk(ratio == exp_ratio, {req, " ratio"}, ratio, exp_ratio);
        chk(err_first == exp_err, {req, " R9 prog_err"}, err_first, exp_err);
    endtask

    // R1: outputs while reset is held.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(mod_ctl == 1'b1, "R1 mod_ctl in reset", int'(mod_ctl), 1);
        chk(load_stb == 1'b1, "R1 load_stb in reset", int'(load_stb), 1);
        chk(div_out == 1'b1, "R1 div_out in reset", int'(div_out), 1);
        chk(prog_err == 1'b0, "R1 prog_err in reset", int'(prog_err), 0);
        rst_n = 1'b1;
    endtask

    // R6: low band ratios.
    task automatic t_low_band();
        run_case("R6 P77 S6", 1'b0, 5'd13, 6'd6, 77, 6, 2470, 0);
        run_case("R6 P75 S0", 1'b0, 5'd11, 6'd0, 75, 0, 2400, 0);
    endtask

    // R7: high band ratios.
    task automatic t_high_band();
        run_case("R7 P122 S38", 1'b1, 5'd26, 6'd38, 122, 38, 5818, 0);
        run_case("R7 P105 S48", 1'b1, 5'd9, 6'd48, 105, 48, 4992, 0);
    endtask

    // R8 and R9: low band with bit 5 of S set; then a clean load clears the flag.
    task automatic t_masked_s();
        run_case("R8 P76 S33 low", 1'b0, 5'd12, 6'd33, 76, 1, 2433, 1);
        run_case("R9 clear P76 S1", 1'b0, 5'd12, 6'd1, 76, 1, 2433, 0);
    endtask

    // R11: channel stepping by K.
    task automatic t_stepping();
        run_case("R11 low S5", 1'b0, 5'd11, 6'd5, 75, 5, 2405, 0);
        run_case("R11 low S10", 1'b0, 5'd11, 6'd10, 75, 10, 2410, 0);
        run_case("R11 high S20", 1'b1, 5'd9, 6'd20, 105, 20, 5020, 0);
    endtask

    // R10: changes made mid-cycle apply from the next division cycle.
    task automatic t_midcycle();
        int cyc, zeros, ratio, mono_bad, div_bad, err_first;
        band_sel = 1'b0; p_prog = 5'd13; s_prog = 6'd6;
        wait_load();
        measure(1'b0, 10, 1'b1, 5'd26, 6'd38, cyc, zeros, ratio, mono_bad, div_bad, err_first);
        chk(cyc == 77, "R10 old period kept", cyc, 77);
        chk(zeros == 6, "R10 old S kept", zeros, 6);
        chk(ratio == 2470, "R10 old ratio kept", ratio, 2470);
        measure(1'b1, 0, 1'b1, 5'd26, 6'd38, cyc, zeros, ratio, mono_bad, div_bad, err_first);
        chk(cyc == 122, "R10 new period", cyc, 122);
        chk(zeros == 38, "R10 new S", zeros, 38);
        chk(ratio == 5818, "R10 new ratio", ratio, 5818);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_low_band();
        t_high_band();
        t_masked_s();
        t_stepping();
        t_midcycle();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule